// File: doc/BRIEF.md
# Chained Buffer DMA Channel

This block is one DMA channel that moves a stream of equally sized buffers from a ring of source buffer descriptors into a ring of destination buffer descriptors. Each descriptor occupies two 32-bit words in memory: a 48-bit physical buffer address and a fill flag. A producer marks a source buffer full, and a consumer marks a destination buffer empty. The channel copies a full source buffer into an empty destination buffer word by word. It then hands the destination to the consumer by setting its flag, and returns the source to the producer by clearing its flag.

The scan policy depends on the polling period input. With a nonzero period the channel works strictly in ring order: when the expected descriptor is not ready, it sleeps for the programmed number of cycles and reads the same descriptor again. With a zero period it searches each ring round-robin for the first usable descriptor, starting just after the last one used. Any failed memory access stops the channel, latches one of four cause codes and raises an interrupt. Lowering the run input returns the channel to idle and clears the interrupt.

The memory port is a single-word master with a same-cycle response. A request with its address, write enable and write data is answered in the same cycle by read data and an error flag.

Top module: `cbdma_channel`

## Requirements
- R1: A descriptor for ring index i sits at base + 8*i. The low word (bit positions 31..0 of the 48-bit address) is at +0. The high word at +4 carries the fill flag in bit 31, zeros in bits 30..16 and address bits 47..32 in bits 15..0. A flag value of 1 means full and 0 means empty. The channel reads the low word first, then the high word.
- R2: A copy moves cfg_buf_bytes/4 words. Word k is read from source address + 4*k and then written to destination address + 4*k, with k counting up from 0.
- R3: After the data, the channel writes the destination descriptor (low word = address, high word with flag 1). It then writes the source descriptor (low word = address, high word with flag 0). Each descriptor is written low word first, and both keep their stored addresses.
- R4: With cfg_period = P > 0, an unready descriptor is read again exactly P+2 cycles after its previous read. The ring index does not move and nothing is written meanwhile.
- R5: After each copy both ring indices advance by one. An index wraps from count-1 to 0, and each ring wraps on its own count.
- R6: With cfg_period = 0, a source descriptor that is not full and a destination descriptor that is not empty are skipped to the next index at once. The search continues round-robin from the index after the last buffer used.
- R7: A memory access with mem_err stops the channel. err_code becomes 1 for a source descriptor access, 2 for source data, 3 for a destination descriptor access or 4 for destination data. irq is set, busy clears, and mem_req stays low until stop.
- R8: Driving cfg_run low returns the channel to idle within one cycle. This clears err_code, irq and busy, and resets both ring indices to 0.
- R9: After reset, busy, irq, mem_req and err_code are 0 and both indices are 0.
- R10: busy is 1 while the channel runs without a fault. src_idx and dst_idx show the ring positions currently being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_run | input | 1 | Run control: high starts the channel, low stops it and acknowledges a fault |
| cfg_src_base | input | 48 | Byte address of the source descriptor ring |
| cfg_dst_base | input | 48 | Byte address of the destination descriptor ring |
| cfg_src_count | input | IDX_W | Number of source descriptors |
| cfg_dst_count | input | IDX_W | Number of destination descriptors |
| cfg_buf_bytes | input | LEN_W | Buffer length in bytes, a multiple of 4 |
| cfg_period | input | PER_W | Poll period; zero selects out-of-order scanning |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 48 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the request cycle |
| mem_err | input | 1 | Access error, valid in the request cycle |
| busy | output | 1 | Channel running without a fault |
| irq | output | 1 | Fault interrupt |
| err_code | output | 3 | Fault cause (0 none, 1 to 4 as in R7) |
| src_idx | output | IDX_W | Current source ring index |
| dst_idx | output | IDX_W | Current destination ring index |

## Verification
Every memory access takes one cycle, so each write appears on the port in the cycle its state is entered. A scoreboard monitor samples the write at the falling edge of that cycle and compares it in order with the addresses and words that the driver task derived from the descriptors it placed in memory. err_code, irq and busy change on the clock edge after the faulting access, and the indices change on the edge that ends a copy or a stop. The bench therefore reads them only after a bounded wait for the interrupt or for the scoreboard to drain, plus one edge. The poll spacing is measured by the monitor as the cycle distance between two reads of the same descriptor word, which must equal the period plus two.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;

    localparam int PADDR_W = 48;
    localparam int WORD_W  = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRC_LO,
        ST_SRC_HI,
        ST_DST_LO,
        ST_DST_HI,
        ST_RD,
        ST_WR,
        ST_DUPD_LO,
        ST_DUPD_HI,
        ST_SUPD_LO,
        ST_SUPD_HI,
        ST_WAIT,
        ST_FAULT
    } chan_state_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_SRC_DESC = 3'd1,
        FLT_SRC_DATA = 3'd2,
        FLT_DST_DESC = 3'd3,
        FLT_DST_DATA = 3'd4
    } fault_e;

    // Upper descriptor word: fill flag, 15 zero bits, address bits 47..32
    function automatic logic [WORD_W-1:0] desc_hi(input logic full,
                                                  input logic [PADDR_W-1:0] a);
        return {full, 15'd0, a[47:32]};
    endfunction

    function automatic logic [WORD_W-1:0] desc_lo(input logic [PADDR_W-1:0] a);
        return a[31:0];
    endfunction

    // Which fault cause an access made in a given state maps to
    function automatic fault_e fault_of(input chan_state_e s);
        case (s)
            ST_SRC_LO, ST_SRC_HI, ST_SUPD_LO, ST_SUPD_HI: return FLT_SRC_DESC;
            ST_RD:                                        return FLT_SRC_DATA;
            ST_DST_LO, ST_DST_HI, ST_DUPD_LO, ST_DUPD_HI: return FLT_DST_DESC;
            ST_WR:                                        return FLT_DST_DATA;
            default:                                      return FLT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cbdma_ring_ptr.sv
module cbdma_ring_ptr #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [IDX_W-1:0] count,
    output logic [IDX_W-1:0] idx
);
    logic at_end;
    assign at_end = (idx >= count - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= at_end ? '0 : idx + 1'b1;
        end
    end

    // R5: stepping from the last descriptor lands on index 0
    assert_ring_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && count != '0 && idx == count - 1'b1) |=> (idx == '0));

endmodule

// File: rtl/cbdma_wait_timer.sv
module cbdma_wait_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PER_W-1:0] period,
    output logic             done
);
    logic [PER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q <= PER_W'(1));

endmodule

// File: rtl/cbdma_ctrl.sv
module cbdma_ctrl
    import cbdma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 16,
    parameter int PER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_run,
    input  logic [PADDR_W-1:0] cfg_src_base,
    input  logic [PADDR_W-1:0] cfg_dst_base,
    input  logic [LEN_W-1:0]   cfg_buf_bytes,
    input  logic [PER_W-1:0]   cfg_period,
    input  logic [IDX_W-1:0]   src_idx,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic               timer_done,
    output logic               ring_clear,
    output logic               src_step,
    output logic               dst_step,
    output logic               timer_load,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_err,
    output logic               busy,
    output fault_e             fault
);
    localparam int WCNT_W = LEN_W - 2;

    chan_state_e        state_q;
    fault_e             fault_q;
    logic [PADDR_W-1:0] src_buf_q;
    logic [PADDR_W-1:0] dst_buf_q;
    logic [WCNT_W-1:0]  word_q;
    logic [WORD_W-1:0]  data_q;
    logic               wait_dst_q;

    logic [WCNT_W-1:0]  nwords;
    logic               polled;
    logic               acc_ok;
    logic               rd_full;
    logic [PADDR_W-1:0] src_desc_a;
    logic [PADDR_W-1:0] dst_desc_a;
    logic [PADDR_W-1:0] byte_off;

    assign nwords     = cfg_buf_bytes[LEN_W-1:2];
    assign polled     = (cfg_period != '0);
    assign acc_ok     = cfg_run && !mem_err;
    assign rd_full    = mem_rdata[WORD_W-1];
    assign src_desc_a = cfg_src_base + PADDR_W'({src_idx, 3'b000});
    assign dst_desc_a = cfg_dst_base + PADDR_W'({dst_idx, 3'b000});
    assign byte_off   = PADDR_W'({word_q, 2'b00});

    // Memory port, decoded from the state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_SRC_LO:  mem_addr = src_desc_a;
            ST_SRC_HI:  mem_addr = src_desc_a + PADDR_W'(4);
            ST_DST_LO:  mem_addr = dst_desc_a;
            ST_DST_HI:  mem_addr = dst_desc_a + PADDR_W'(4);
            ST_RD:      mem_addr = src_buf_q + byte_off;
            ST_WR: begin
                mem_addr  = dst_buf_q + byte_off;
                mem_we    = 1'b1;
                mem_wdata = data_q;
            end
            ST_DUPD_LO: begin
                mem_addr  = dst_desc_a;
                mem_we    = 1'b1;
                mem_wdata = desc_lo(dst_buf_q);
            end
            ST_DUPD_HI: begin
                mem_addr  = dst_desc_a + PADDR_W'(4);
                mem_we    = 1'b1;
                mem_wdata = desc_hi(1'b1, dst_buf_q);
            end
            ST_SUPD_LO: begin
                mem_addr  = src_desc_a;
                mem_we    = 1'b1;
                mem_wdata = desc_lo(src_buf_q);
            end
            ST_SUPD_HI: begin
                mem_addr  = src_desc_a + PADDR_W'(4);
                mem_we    = 1'b1;
                mem_wdata = desc_hi(1'b0, src_buf_q);
            end
            default:    mem_req = 1'b0;
        endcase
    end

    // Ring index and timer controls
    always_comb begin
        ring_clear = (state_q == ST_IDLE);
        src_step   = acc_ok && (((state_q == ST_SRC_HI) && !rd_full && !polled)
                                || (state_q == ST_SUPD_HI));
        dst_step   = acc_ok && (((state_q == ST_DST_HI) && rd_full && !polled)
                                || (state_q == ST_SUPD_HI));
        timer_load = acc_ok && polled &&
                     (((state_q == ST_SRC_HI) && !rd_full) ||
                      ((state_q == ST_DST_HI) && rd_full));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            fault_q    <= FLT_NONE;
            src_buf_q  <= '0;
            dst_buf_q  <= '0;
            word_q     <= '0;
            data_q     <= '0;
            wait_dst_q <= 1'b0;
        end else if (!cfg_run) begin
            state_q <= ST_IDLE;
            fault_q <= FLT_NONE;
        end else if (mem_req && mem_err) begin
            state_q <= ST_FAULT;
            fault_q <= fault_of(state_q);
        end else begin
            case (state_q)
                ST_IDLE:   state_q <= ST_SRC_LO;
                ST_SRC_LO: begin
                    src_buf_q[31:0] <= mem_rdata;
                    state_q         <= ST_SRC_HI;
                end
                ST_SRC_HI: begin
                    src_buf_q[PADDR_W-1:32] <= mem_rdata[PADDR_W-33:0];
                    if (rd_full) begin
                        state_q <= ST_DST_LO;
                    end else if (polled) begin
                        wait_dst_q <= 1'b0;
                        state_q    <= ST_WAIT;
                    end else begin
                        state_q <= ST_SRC_LO;
                    end
                end
                ST_DST_LO: begin
                    dst_buf_q[31:0] <= mem_rdata;
                    state_q         <= ST_DST_HI;
                end
                ST_DST_HI: begin
                    dst_buf_q[PADDR_W-1:32] <= mem_rdata[PADDR_W-33:0];
                    word_q                  <= '0;
                    if (!rd_full) begin
                        state_q <= (nwords == '0) ? ST_DUPD_LO : ST_RD;
                    end else if (polled) begin
                        wait_dst_q <= 1'b1;
                        state_q    <= ST_WAIT;
                    end else begin
                        state_q <= ST_DST_LO;
                    end
                end
                ST_RD: begin
                    data_q  <= mem_rdata;
                    state_q <= ST_WR;
                end
                ST_WR: begin
                    word_q  <= word_q + 1'b1;
                    state_q <= (word_q + 1'b1 >= nwords) ? ST_DUPD_LO : ST_RD;
                end
                ST_DUPD_LO: state_q <= ST_DUPD_HI;
                ST_DUPD_HI: state_q <= ST_SUPD_LO;
                ST_SUPD_LO: state_q <= ST_SUPD_HI;
                ST_SUPD_HI: state_q <= ST_SRC_LO;
                ST_WAIT: begin
                    if (timer_done) begin
                        state_q <= wait_dst_q ? ST_DST_LO : ST_SRC_LO;
                    end
                end
                default:    state_q <= state_q;
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE) && (state_q != ST_FAULT);
    assign fault = fault_q;

    // R7: a latched fault silences the memory port
    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (fault_q != FLT_NONE) |-> !mem_req);

    // R7: the cause code holds while the channel stays enabled
    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fault_q != FLT_NONE && cfg_run) |=> (fault_q == $past(fault_q)));

    // R8: stop returns to idle and clears the cause in one cycle
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_run |=> (fault_q == FLT_NONE && !busy));

    // R2: no data write past the programmed buffer length
    assert_copy_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && state_q == ST_WR) |-> (word_q < nwords));

endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 16,
    parameter int PER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_run,
    input  logic [PADDR_W-1:0] cfg_src_base,
    input  logic [PADDR_W-1:0] cfg_dst_base,
    input  logic [IDX_W-1:0]   cfg_src_count,
    input  logic [IDX_W-1:0]   cfg_dst_count,
    input  logic [LEN_W-1:0]   cfg_buf_bytes,
    input  logic [PER_W-1:0]   cfg_period,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_err,
    output logic               busy,
    output logic               irq,
    output logic [2:0]         err_code,
    output logic [IDX_W-1:0]   src_idx,
    output logic [IDX_W-1:0]   dst_idx
);
    localparam int N_RINGS = 2;

    logic             ring_clear;
    logic             timer_load;
    logic             timer_done;
    logic             step_src;
    logic             step_dst;
    fault_e           fault;
    logic             ring_step  [N_RINGS];
    logic [IDX_W-1:0] ring_count [N_RINGS];
    logic [IDX_W-1:0] ring_idx   [N_RINGS];

    assign ring_step[0]  = step_src;
    assign ring_step[1]  = step_dst;
    assign ring_count[0] = cfg_src_count;
    assign ring_count[1] = cfg_dst_count;

    for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
        cbdma_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
            .clk   (clk),
            .rst   (rst),
            .clear (ring_clear),
            .step  (ring_step[r]),
            .count (ring_count[r]),
            .idx   (ring_idx[r])
        );
    end

    cbdma_wait_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (timer_load),
        .period (cfg_period),
        .done   (timer_done)
    );

    cbdma_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W), .PER_W(PER_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cfg_run       (cfg_run),
        .cfg_src_base  (cfg_src_base),
        .cfg_dst_base  (cfg_dst_base),
        .cfg_buf_bytes (cfg_buf_bytes),
        .cfg_period    (cfg_period),
        .src_idx       (ring_idx[0]),
        .dst_idx       (ring_idx[1]),
        .timer_done    (timer_done),
        .ring_clear    (ring_clear),
        .src_step      (step_src),
        .dst_step      (step_dst),
        .timer_load    (timer_load),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_err       (mem_err),
        .busy          (busy),
        .fault         (fault)
    );

    assign src_idx  = ring_idx[0];
    assign dst_idx  = ring_idx[1];
    assign err_code = fault;
    assign irq      = (fault != FLT_NONE);

endmodule

// File: tb/cbdma_channel_tb.sv
module cbdma_channel_tb;

    localparam int IDX_W = 8;
    localparam int LEN_W = 16;
    localparam int PER_W = 16;

    typedef struct {
        logic [47:0] addr;
        logic [31:0] data;
        string       tag;
    } wr_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_run = 1'b0;
    logic [47:0]       cfg_src_base = '0;
    logic [47:0]       cfg_dst_base = '0;
    logic [IDX_W-1:0]  cfg_src_count = 8'd1;
    logic [IDX_W-1:0]  cfg_dst_count = 8'd1;
    logic [LEN_W-1:0]  cfg_buf_bytes = 16'd16;
    logic [PER_W-1:0]  cfg_period = '0;
    logic              mem_req, mem_we, mem_err;
    logic [47:0]       mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;
    logic              busy, irq;
    logic [2:0]        err_code;
    logic [IDX_W-1:0]  src_idx, dst_idx;

    logic [31:0] mem [0:1023];
    wr_item_t    exp_q [$];
    int          n_cmp = 0;
    int          n_bad = 0;
    longint      cyc = 0;
    longint      last_poll = -1;
    longint      poll_gap = 0;
    logic [47:0] poll_addr = 48'hFFFF_FFFF;
    bit          finished = 0;

    always #4 clk = ~clk;

    cbdma_channel #(.IDX_W(IDX_W), .LEN_W(LEN_W), .PER_W(PER_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_run(cfg_run),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
        .cfg_src_count(cfg_src_count), .cfg_dst_count(cfg_dst_count),
        .cfg_buf_bytes(cfg_buf_bytes), .cfg_period(cfg_period),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .busy(busy), .irq(irq), .err_code(err_code),
        .src_idx(src_idx), .dst_idx(dst_idx)
    );

    // Memory model: 4 KiB of words, anything above faults
    assign mem_err   = mem_req && (mem_addr >= 48'h1000);
    assign mem_rdata = mem_err ? 32'h0 : mem[mem_addr[11:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we && !mem_err) mem[mem_addr[11:2]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every accepted write must match the next expected one
    always @(negedge clk) begin
        if (!rst && mem_req && !mem_we && mem_addr == poll_addr) begin
            if (last_poll >= 0) poll_gap = cyc - last_poll;
            last_poll = cyc;
        end
        if (!rst && mem_req && mem_we && !mem_err) begin
            if (exp_q.size() == 0) begin
                chk("R2/R3 unexpected write addr", mem_addr, 48'hDEAD);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk({it.tag, " addr"}, mem_addr, it.addr);
                chk({it.tag, " data"}, mem_wdata, it.data);
            end
        end
    end

    function automatic logic [31:0] pat(input logic [47:0] a);
        return 32'hC3A5_0000 ^ (a[31:0] * 32'd2654435761);
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    endtask

    task automatic set_desc(input logic [47:0] base, input int i, input logic full,
                            input logic [47:0] a);
        logic [47:0] da;
        da = base + 48'(8 * i);
        mem[da[11:2]]     = a[31:0];
        mem[da[11:2] + 1] = {full, 15'd0, a[47:32]};
    endtask

    task automatic fill_buf(input logic [47:0] a, input int nw);
        for (int k = 0; k < nw; k++) mem[a[11:2] + 10'(k)] = pat(a + 48'(4 * k));
    endtask

    // Driver: push the writes that one copy must produce
    task automatic expect_copy(input logic [47:0] sbase, input int si, input logic [47:0] sbuf,
                               input logic [47:0] dbase, input int di, input logic [47:0] dbuf,
                               input int nw);
        for (int k = 0; k < nw; k++)
            exp_q.push_back('{dbuf + 48'(4 * k), pat(sbuf + 48'(4 * k)), "R2 data"});
        exp_q.push_back('{dbase + 48'(8 * di),     dbuf[31:0],                    "R3 dst lo"});
        exp_q.push_back('{dbase + 48'(8 * di + 4), {1'b1, 15'd0, dbuf[47:32]},     "R3 dst hi"});
        exp_q.push_back('{sbase + 48'(8 * si),     sbuf[31:0],                    "R3 src lo"});
        exp_q.push_back('{sbase + 48'(8 * si + 4), {1'b0, 15'd0, sbuf[47:32]},     "R3 src hi"});
    endtask

    task automatic drain(input string tag);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " scoreboard drained"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    task automatic stop_run();
        @(negedge clk);
        cfg_run = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_fault(input logic [2:0] exp_code, input string tag);
        int n;
        @(negedge clk);
        cfg_run = 1'b1;
        n = 0;
        while (!irq && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " irq"}, 64'(irq), 64'd1);
        chk({tag, " err_code"}, 64'(err_code), 64'(exp_code));
        chk({tag, " busy low in fault"}, 64'(busy), 64'd0);
        begin
            int reqs;
            reqs = 0;
            repeat (6) begin
                @(negedge clk);
                if (mem_req) reqs++;
            end
            chk({tag, " no requests in fault"}, 64'(reqs), 64'd0);
        end
        stop_run();
        chk("R8 irq cleared by stop", 64'(irq), 64'd0);
        chk("R8 err_code cleared by stop", 64'(err_code), 64'd0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk("R9 busy", 64'(busy), 64'd0);
        chk("R9 irq", 64'(irq), 64'd0);
        chk("R9 err_code", 64'(err_code), 64'd0);
        chk("R9 mem_req", 64'(mem_req), 64'd0);
        chk("R9 src_idx", 64'(src_idx), 64'd0);
        chk("R9 dst_idx", 64'(dst_idx), 64'd0);

        // ---- In-order, period 9, 3 source / 2 destination descriptors ----
        cfg_src_base  = 48'h000;
        cfg_dst_base  = 48'h040;
        cfg_src_count = 8'd3;
        cfg_dst_count = 8'd2;
        cfg_buf_bytes = 16'd16;
        cfg_period    = 16'd9;
        for (int i = 0; i < 3; i++) begin
            set_desc(48'h000, i, 1'b1, 48'h100 + 48'(64 * i));
            fill_buf(48'h100 + 48'(64 * i), 4);
        end
        for (int j = 0; j < 2; j++) set_desc(48'h040, j, 1'b0, 48'h400 + 48'(64 * j));
        expect_copy(48'h000, 0, 48'h100, 48'h040, 0, 48'h400, 4);
        expect_copy(48'h000, 1, 48'h140, 48'h040, 1, 48'h440, 4);
        @(negedge clk);
        cfg_run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 busy while running", 64'(busy), 64'd1);
        drain("R2 in-order first two copies");
        repeat (60) @(negedge clk);
        chk("R4 src_idx held while destination full", 64'(src_idx), 64'd2);
        chk("R5 dst_idx wrapped to 0", 64'(dst_idx), 64'd0);
        chk("R1 dst0 flag set", 64'(mem[(48'h040 + 4) >> 2]), 64'h8000_0000);
        chk("R1 src0 flag cleared", 64'(mem[(48'h000 + 4) >> 2]), 64'h0);
        // consumer empties destination 0
        expect_copy(48'h000, 2, 48'h180, 48'h040, 0, 48'h400, 4);
        poll_addr = 48'h000;
        last_poll = -1;
        set_desc(48'h040, 0, 1'b0, 48'h400);
        drain("R4 copy after destination emptied");
        repeat (60) @(negedge clk);
        chk("R5 src_idx wrapped to 0", 64'(src_idx), 64'd0);
        chk("R5 dst_idx advanced to 1", 64'(dst_idx), 64'd1);
        chk("R4 poll gap equals period+2", 64'(poll_gap), 64'd11);
        chk("R3 src2 address preserved", 64'(mem[(48'h010) >> 2]), 64'h180);
        poll_addr = 48'hFFFF_FFFF;
        stop_run();
        chk("R8 busy low after stop", 64'(busy), 64'd0);
        chk("R8 src_idx reset by stop", 64'(src_idx), 64'd0);

        // ---- Out-of-order, period 0, 4 / 4 descriptors, 8-word buffers ----
        clear_mem();
        cfg_period    = 16'd0;
        cfg_src_count = 8'd4;
        cfg_dst_count = 8'd4;
        cfg_buf_bytes = 16'd32;
        for (int i = 0; i < 4; i++) begin
            set_desc(48'h000, i, (i >= 2), 48'h100 + 48'(64 * i));
            fill_buf(48'h100 + 48'(64 * i), 8);
            set_desc(48'h040, i, (i == 0 || i == 2), 48'h400 + 48'(64 * i));
        end
        expect_copy(48'h000, 2, 48'h180, 48'h040, 1, 48'h440, 8);
        expect_copy(48'h000, 3, 48'h1C0, 48'h040, 3, 48'h4C0, 8);
        @(negedge clk);
        cfg_run = 1'b1;
        drain("R6 out-of-order skip to first usable");
        repeat (40) @(negedge clk);
        chk("R6 dst search resumes after index 3", 64'(dst_idx), 64'd0);
        chk("R6 dst1 now full", 64'(mem[(48'h040 + 12) >> 2]), 64'h8000_0000);
        chk("R6 dst3 now full", 64'(mem[(48'h040 + 28) >> 2]), 64'h8000_0000);
        chk("R6 src3 now empty", 64'(mem[(48'h000 + 28) >> 2]), 64'h0);
        chk("R10 busy while scanning", 64'(busy), 64'd1);
        stop_run();

        // ---- Fault causes ----
        clear_mem();
        cfg_buf_bytes = 16'd16;
        cfg_src_count = 8'd2;
        cfg_dst_count = 8'd2;
        cfg_src_base  = 48'h2000;
        cfg_dst_base  = 48'h040;
        run_fault(3'd1, "R7 source descriptor fault");

        cfg_src_base = 48'h000;
        set_desc(48'h000, 0, 1'b1, 48'h2000);
        set_desc(48'h040, 0, 1'b0, 48'h400);
        run_fault(3'd2, "R7 source data fault");

        set_desc(48'h000, 0, 1'b1, 48'h100);
        fill_buf(48'h100, 4);
        cfg_dst_base = 48'h3000;
        run_fault(3'd3, "R7 destination descriptor fault");

        cfg_dst_base = 48'h040;
        set_desc(48'h040, 0, 1'b0, 48'h2000);
        run_fault(3'd4, "R7 destination data fault");
        chk("R7 source stays full after fault", 64'(mem[1]), 64'h8000_0000);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule